// File: doc/BRIEF.md
# Multi-Channel Sequence Number Checker

This block judges whether packets on many independent flows arrive in order, at a rate of one judgement per clock. A request carries a channel number and a 16-bit packet sequence number. The block reads that channel's stored next-expected number from an on-chip table and compares it with the sequence number using wrap-around arithmetic. It returns a single verdict: pass for a packet that is in order, or ahead with a gap, and fail for a late packet. On a pass it writes back the next expected number. Packets are neither stored nor reordered. The block produces only the verdict.

Sequence number zero is a wildcard that always passes. The stored expected value never becomes zero, because the value after 0xFFFF is 1. The table is read in one pipeline stage and judged and written in the next. A forwarding path lets requests on consecutive clocks target the same channel and still see each other's updates. Reset, or a one-cycle `init` pulse, sweeps the table so that every channel expects 1. Requests are held off while the sweep runs.

Top module: `chan_seq_checker`

## Requirements
- R1: A request with sequence number 0 always passes, whatever the channel's stored expected value.
- R2: A non-zero sequence number passes when (seq − expected) mod 2^16 has bit 15 clear. This covers seq equal to expected, and seq ahead of expected by up to 32767 with any gap in between.
- R3: A non-zero sequence number fails when (seq − expected) mod 2^16 has bit 15 set. Seq ahead by exactly 32768 therefore fails.
- R4: On a pass, the channel's expected value becomes seq+1 modulo 2^16, except that seq 0xFFFF makes it 1. Zero is never stored.
- R5: On a fail, the channel's expected value is left unchanged.
- R6: Each channel keeps its own expected value. A request on one channel does not alter any other channel.
- R7: A request accepted at a clock edge (`req_valid` and `req_ready` both high) produces exactly one response. That response has `rsp_valid` high for one cycle, two edges later, and carries the request's channel in `rsp_chan`. One request can be accepted every clock.
- R8: A request accepted on the clock after another request to the same channel is judged against the value that the earlier request wrote.
- R9: After reset, and after a one-cycle `init` pulse, every channel expects 1. `req_ready` is low while `init` is high and for CHANNELS cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts a table sweep |
| init | input | 1 | Synchronous request to set every channel's expected value to 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_chan | input | $clog2(CHANNELS) | Channel of the request |
| req_seq | input | SEQ_W | Packet sequence number |
| rsp_valid | output | 1 | Verdict present |
| rsp_chan | output | $clog2(CHANNELS) | Channel the verdict belongs to |
| rsp_pass | output | 1 | 1 = in order (pass), 0 = late (fail) |

## Verification
A corrupted table entry or a stale forwarded value is not visible right away. It shows up as a wrong `rsp_pass` on the next request to that channel, which may come many cycles later. The bench therefore sends requests whose verdict depends on the exact stored value: seq set to expected, seq just behind expected, and seq exactly half the range ahead. It also sends same-channel requests on consecutive cycles, so that a forwarding fault shows within two cycles. Errors in the pipeline timing appear at once as a `rsp_valid` in the wrong cycle or with the wrong `rsp_chan`. The bench compares both outputs on every clock against a behavioural model.

// File: rtl/chan_seq_checker.sv
module chan_seq_checker #(
  parameter int CHANNELS = 64,
  parameter int SEQ_W = 16,
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [SEQ_W-1:0] req_seq,
  output logic             rsp_valid,
  output logic [CH_W-1:0]  rsp_chan,
  output logic             rsp_pass
);

  logic [SEQ_W-1:0] table_q [CHANNELS];

  logic             sweep;
  logic [CH_W-1:0]  sweep_idx;

  logic             s1_valid;
  logic [CH_W-1:0]  s1_chan;
  logic [SEQ_W-1:0] s1_seq;
  logic [SEQ_W-1:0] rd_exp;

  logic             fwd_valid;
  logic [CH_W-1:0]  fwd_chan;
  logic [SEQ_W-1:0] fwd_exp;

  logic             accept;
  logic [SEQ_W-1:0] cur_exp;
  logic [SEQ_W-1:0] diff;
  logic [SEQ_W-1:0] bumped;
  logic [SEQ_W-1:0] next_exp;
  logic             pass;
  logic             wr_en;

  assign req_ready = ~sweep & ~init;
  assign accept    = req_valid & req_ready;

  assign cur_exp  = (fwd_valid && fwd_chan == s1_chan) ? fwd_exp : rd_exp;
  assign diff     = s1_seq - cur_exp;
  assign pass     = (s1_seq == '0) | ~diff[SEQ_W-1];
  assign bumped   = s1_seq + SEQ_W'(1);
  assign next_exp = (bumped == '0) ? SEQ_W'(1) : bumped;
  assign wr_en    = s1_valid & pass;

  always_ff @(posedge clk) begin
    if (sweep)
      table_q[sweep_idx] <= SEQ_W'(1);
    else if (wr_en)
      table_q[s1_chan] <= next_exp;
    if (accept)
      rd_exp <= table_q[req_chan];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sweep     <= 1'b1;
      sweep_idx <= '0;
      s1_valid  <= 1'b0;
      fwd_valid <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      if (init) begin
        sweep     <= 1'b1;
        sweep_idx <= '0;
      end else if (sweep) begin
        sweep_idx <= sweep_idx + CH_W'(1);
        if (sweep_idx == CH_W'(CHANNELS - 1))
          sweep <= 1'b0;
      end
      s1_valid  <= accept;
      fwd_valid <= wr_en;
      rsp_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_chan <= req_chan;
      s1_seq  <= req_seq;
    end
    fwd_chan <= s1_chan;
    fwd_exp  <= next_exp;
    rsp_chan <= s1_chan;
    rsp_pass <= pass;
  end

endmodule

// File: rtl/chan_seq_checker_props.sv
module chan_seq_checker_props #(
  parameter int CHANNELS = 64,
  parameter int SEQ_W = 16,
  localparam int CH_W = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init,
  input logic             req_valid,
  input logic             req_ready,
  input logic [CH_W-1:0]  req_chan,
  input logic [SEQ_W-1:0] req_seq,
  input logic             rsp_valid,
  input logic [CH_W-1:0]  rsp_chan,
  input logic             rsp_pass,
  input logic             fwd_valid,
  input logic [SEQ_W-1:0] fwd_exp
);

  assert_init_holds_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> !req_ready);

  assert_fixed_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> ##1 (rsp_valid && rsp_chan == $past(req_chan, 2)));

  assert_no_orphan_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready, 2));

  assert_zero_seq_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_seq == '0) |=> ##1 rsp_pass);

  assert_never_store_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> fwd_exp != '0);

endmodule

bind chan_seq_checker chan_seq_checker_props #(.CHANNELS(CHANNELS), .SEQ_W(SEQ_W)) u_props (
  .clk(clk), .rst_n(rst_n), .init(init),
  .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan), .req_seq(req_seq),
  .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_pass(rsp_pass),
  .fwd_valid(fwd_valid), .fwd_exp(fwd_exp)
);

// File: tb/test_chan_seq_checker.sv
`timescale 1ns/1ps
module test_chan_seq_checker;
  localparam int NCH = 16;
  localparam int CW = $clog2(NCH);

  logic clk = 1'b0;
  logic rst_n, init, req_valid, req_ready, rsp_valid, rsp_pass;
  logic [CW-1:0] req_chan, rsp_chan;
  logic [15:0] req_seq;

  always #2.5 clk = ~clk;

  chan_seq_checker #(.CHANNELS(NCH), .SEQ_W(16)) i_chan_seq_checker (
    .clk(clk), .rst_n(rst_n), .init(init),
    .req_valid(req_valid), .req_ready(req_ready), .req_chan(req_chan), .req_seq(req_seq),
    .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_pass(rsp_pass)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ref_exp [NCH];
  int q_due[$];
  int q_chan[$];
  int q_pass[$];
  string q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic bit model_pass(int e, int s);
    return (s == 0) || (((s - e) & 65535) < 32768);
  endfunction

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      automatic bit due_now = (q_due.size() > 0) && (q_due[0] == cyc);
      chk(rsp_valid == due_now, "R7 rsp_valid timing", rsp_valid, due_now);
      if (due_now) begin
        if (rsp_valid) begin
          chk(rsp_chan == q_chan[0], "R7 rsp_chan", rsp_chan, q_chan[0]);
          chk(rsp_pass == q_pass[0], q_tag[0], rsp_pass, q_pass[0]);
        end
        void'(q_due.pop_front()); void'(q_chan.pop_front());
        void'(q_pass.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  task automatic send(int ch, int s, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_chan = CW'(ch); req_seq = 16'(s);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    begin
      automatic bit p = model_pass(ref_exp[ch], s);
      automatic string t = (tag != "") ? tag : ((s == 0) ? "R1" : (p ? "R2" : "R3"));
      q_due.push_back(cyc + 2); q_chan.push_back(ch);
      q_pass.push_back(p); q_tag.push_back({t, " rsp_pass"});
      if (p) ref_exp[ch] = (s == 65535) ? 1 : s + 1;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); req_valid = 1'b0; end
  endtask

  task automatic init_pulse();
    int n;
    @(negedge clk); req_valid = 1'b0; init = 1'b1;
    @(negedge clk); init = 1'b0;
    for (int c = 0; c < NCH; c++) ref_exp[c] = 1;
    n = 0; #1;
    while (!req_ready && n < 10 * NCH) begin n++; @(negedge clk); #1; end
    chk(n == NCH, "R9 ready-low cycles after init", n, NCH);
  endtask

  initial begin
    #(150000 * 5);
    fails++; checks++;
    $display("FAIL R7 watchdog: actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init = 1'b0; req_valid = 1'b0; req_chan = '0; req_seq = '0;
    for (int c = 0; c < NCH; c++) ref_exp[c] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R9 ready low after reset", req_ready, 0);
    chk(rsp_valid == 1'b0, "R7 no response after reset", rsp_valid, 0);

    send(0, 1, "R2 equal");
    send(0, 1, "R8 R5 back-to-back late");
    send(0, 2, "R5 unchanged after fail");
    send(0, 0, "R1 zero wildcard");
    send(0, 16'h8001, "R3 half range ahead");
    send(0, 16'h8000, "R2 gap 32767");
    send(1, 16'hFFFF, "R3 one behind");
    send(1, 16'h7000, "R2 gap");
    send(1, 16'hE000, "R2 gap");
    send(1, 16'hFFFF, "R4 wrap top");
    send(1, 16'h8000, "R4 expected is 1 not 0");
    send(2, 5, "R6 ch2");
    send(3, 5, "R6 ch3 untouched by ch2");
    send(2, 5, "R6 R5 ch2 late");
    send(2, 0, "R1 R8 zero back-to-back");
    send(2, 1, "R8 after zero");
    idle(3);

    send(1, 16'h8001, "R2");
    idle(2);
    init_pulse();
    send(1, 16'h9000, "R9 expected reset to 1");
    send(0, 1, "R9 expected reset to 1");

    for (int i = 0; i < 3000; i++) begin
      automatic int ch = (i < 1500) ? ($urandom % 3) : ($urandom % NCH);
      automatic int k = $urandom % 5;
      automatic int s;
      case (k)
        0: s = ref_exp[ch];
        1: s = ref_exp[ch] + ($urandom % 100);
        2: s = ref_exp[ch] - 1 - ($urandom % 100);
        3: s = 0;
        default: s = $urandom;
      endcase
      send(ch, s & 65535, "");
      if ($urandom % 4 == 0) idle(1);
      if (i == 2000) begin idle(1); init_pulse(); end
    end

    idle(5);
    chk(q_due.size() == 0, "R7 every request answered", q_due.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule